// File: doc/BRIEF.md
# Prioritized Interrupt Vector Responder

This block sits between a per-channel interrupt detector and the host bus of an I/O module. It receives a vector of pending flags, one per input channel, and raises an active-low request whenever any flag is set. When the host starts an interrupt-acknowledge cycle for request line 0, the block answers with an 8-bit vector. The top four bits of the vector are a field the host has programmed. The low four bits are the number of the pending channel with the highest number.

Pending flags are cleared outside this block, by host writes to the detector's status register. When the winning flag clears and others remain, the request stays asserted. The next acknowledge then returns the next-highest channel, so each channel gets its own handler. The acknowledge follows the same one-wait-state timing as a register read. The channel number is captured when the cycle is first seen, so the returned vector does not change partway through the cycle.

Top module: `irq_vector_responder`

## Requirements
- R1: After reset, `ack_n` is 1, `data_oe` is 0, `data_out` is 0x00 and the programmable vector field is 0.
- R2: Channel priority is fixed and higher numbers win. The channel field holds the index of the highest set bit of `pending`.
- R3: The vector in `data_out[7:0]` is {programmed field in bits 7..4, channel number in bits 3..0}.
- R4: A write with `vec_wr` high stores `vec_wdata[7:4]` as the programmed field. `vec_wdata[3:0]` has no effect on the returned vector.
- R5: An acknowledge cycle is recognised only when `int_sel_n` is 0 and `addr1` is 0. With `addr1` at 1, `ack_n` stays 1 and `data_oe` stays 0 for the whole cycle.
- R6: Let edge k be the first rising edge at which the cycle is seen. After edge k, `ack_n` is still 1 (the wait state). After edge k+1, `ack_n` is 0 and `data_oe` is 1 for exactly one clock.
- R7: The channel number is captured at edge k. Changes to `pending` after that edge do not alter the vector delivered in that cycle.
- R8: An acknowledge cycle with no channel pending still completes, with the channel field set to 0.
- R9: `irq_req_n` is 0 exactly while any `pending` bit is set. When the highest pending bit clears and lower bits remain, the next acknowledge delivers the next-highest channel.
- R10: Each cycle is acknowledged only once. After the acknowledge clock, `ack_n` stays 1 until `int_sel_n` returns high and a new cycle starts.
- R11: Whenever `data_oe` is 0, `data_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pending | input | NUM_CH | Per-channel pending flags from the detector |
| vec_wr | input | 1 | Write strobe for the vector field register |
| vec_wdata | input | VEC_W | Write data; only the upper field is stored |
| int_sel_n | input | 1 | Active-low interrupt-acknowledge select |
| addr1 | input | 1 | Request-line selector; 0 selects line 0 |
| irq_req_n | output | 1 | Active-low interrupt request, line 0 |
| ack_n | output | 1 | Active-low acknowledge |
| data_oe | output | 1 | High while the vector is driven |
| data_out | output | VEC_W | Vector byte |

## Verification
The assertions check every cycle that an acknowledge is preceded by two cycles of a selected line-0 cycle. They also check that the acknowledge lasts a single clock, that the channel field names the highest bit pending at capture time, and that the data lines are quiet when not enabled. Only the bench scenarios can show the remaining behaviour. That covers the programmed field surviving a write with junk in the low nibble, and line-1 cycles being ignored. It also covers the pending set changing during the wait state, and channels being served one after another as the host clears the winners.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACK  = 2'd2,
      ST_HOLD = 2'd3
   } ack_state_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_CH = 12,
   parameter int IDX_W  = 4
) (
   input  logic [NUM_CH-1:0] req,
   output logic [IDX_W-1:0]  idx,
   output logic              any
);
   logic [NUM_CH-1:0] grant;

   // a bit wins when no higher-numbered bit is set
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_grant
         if (gi == NUM_CH-1) begin : g_top
            assign grant[gi] = req[gi];
         end else begin : g_low
            assign grant[gi] = req[gi] & ~(|req[NUM_CH-1:gi+1]);
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/irq_vec_field.sv
module irq_vec_field #(
   parameter int VEC_W  = 8,
   parameter int USER_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [VEC_W-1:0]  wdata,
   output logic [USER_W-1:0] field
);
   always_ff @(posedge clk) begin
      if (!rst_n)  field <= '0;
      else if (wr) field <= wdata[VEC_W-1 -: USER_W];
   end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
   import irq_vec_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             sel_n,
   input  logic [IDX_W-1:0] win_idx,
   output logic [IDX_W-1:0] cap_idx,
   output logic             drive
);
   ack_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (hit) st_d = ST_WAIT;
         ST_WAIT: st_d = hit ? ST_ACK : ST_IDLE;
         ST_ACK:  st_d = sel_n ? ST_IDLE : ST_HOLD;
         ST_HOLD: if (sel_n) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cap_idx <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && hit) cap_idx <= win_idx;
      end
   end

   assign drive = (st_q == ST_ACK);
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder #(
   parameter int NUM_CH = 12,
   parameter int VEC_W  = 8,
   parameter int USER_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pending,
   input  logic              vec_wr,
   input  logic [VEC_W-1:0]  vec_wdata,
   input  logic              int_sel_n,
   input  logic              addr1,
   output logic              irq_req_n,
   output logic              ack_n,
   output logic              data_oe,
   output logic [VEC_W-1:0]  data_out
);
   localparam int CH_FIELD_W = VEC_W - USER_W;
   localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (IDX_W > CH_FIELD_W) begin : g_bad_width
         $error("channel index does not fit the vector channel field");
      end
      if (USER_W < 1 || USER_W >= VEC_W) begin : g_bad_user
         $error("programmable field width out of range");
      end
   endgenerate

   logic [IDX_W-1:0]  win_idx, cap_idx;
   logic              any_pend, drive, hit;
   logic [USER_W-1:0] user_field;

   irq_prio_enc #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_enc (
      .req (pending),
      .idx (win_idx),
      .any (any_pend)
   );

   irq_vec_field #(.VEC_W(VEC_W), .USER_W(USER_W)) u_field (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (vec_wr),
      .wdata (vec_wdata),
      .field (user_field)
   );

   assign hit = !int_sel_n && !addr1;

   irq_ack_fsm #(.IDX_W(IDX_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .sel_n   (int_sel_n),
      .win_idx (win_idx),
      .cap_idx (cap_idx),
      .drive   (drive)
   );

   assign irq_req_n = !any_pend;
   assign ack_n     = !drive;
   assign data_oe   = drive;
   assign data_out  = drive ? {user_field, CH_FIELD_W'(cap_idx)} : '0;
endmodule

// File: rtl/irq_vector_responder_chk.sv
module irq_vector_responder_chk #(
   parameter int NUM_CH = 12,
   parameter int VEC_W  = 8,
   parameter int USER_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] pending,
   input logic              int_sel_n,
   input logic              addr1,
   input logic              ack_n,
   input logic              data_oe,
   input logic [VEC_W-1:0]  data_out
);
   localparam int CH_FIELD_W = VEC_W - USER_W;

   // R6
   ack_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> ($past(int_sel_n) == 1'b0) && ($past(int_sel_n, 2) == 1'b0));

   // R5
   line0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> ($past(addr1) == 1'b0) && ($past(addr1, 2) == 1'b0));

   // R10
   single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |=> ack_n);

   // R2
   highest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && ($past(pending, 2) != '0)) |->
         (($past(pending, 2) >> data_out[CH_FIELD_W-1:0]) == NUM_CH'(1)));

   // R8
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && ($past(pending, 2) == '0)) |-> (data_out[CH_FIELD_W-1:0] == '0));

   // R11
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> (data_out == '0));
endmodule

bind irq_vector_responder irq_vector_responder_chk #(
   .NUM_CH(NUM_CH), .VEC_W(VEC_W), .USER_W(USER_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pending   (pending),
   .int_sel_n (int_sel_n),
   .addr1     (addr1),
   .ack_n     (ack_n),
   .data_oe   (data_oe),
   .data_out  (data_out)
);

// File: tb/tb_irq_vector_responder.sv
module tb_irq_vector_responder;
   localparam int NUM_CH = 12;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NUM_CH-1:0] pending;
   logic              vec_wr;
   logic [7:0]        vec_wdata;
   logic              int_sel_n;
   logic              addr1;
   logic              irq_req_n, ack_n, data_oe;
   logic [7:0]        data_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_vector_responder dut (
      .clk(clk), .rst_n(rst_n), .pending(pending), .vec_wr(vec_wr),
      .vec_wdata(vec_wdata), .int_sel_n(int_sel_n), .addr1(addr1),
      .irq_req_n(irq_req_n), .ack_n(ack_n), .data_oe(data_oe), .data_out(data_out)
   );

   function automatic logic [3:0] top_chan(input logic [NUM_CH-1:0] p);
      logic [3:0] c = 4'd0;
      for (int i = 0; i < NUM_CH; i++) if (p[i]) c = 4'(i);
      return c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_vec(input logic [7:0] d);
      @(negedge clk);
      vec_wr = 1'b1; vec_wdata = d;
      @(negedge clk);
      vec_wr = 1'b0; vec_wdata = '0;
   endtask

   // runs one acknowledge cycle; returns what was seen in the acknowledge slot
   task automatic ack_cycle(input logic a1, input bit chg, input logic [NUM_CH-1:0] newp,
                            output logic got, output logic oe, output logic [7:0] v);
      @(negedge clk);
      int_sel_n = 1'b0; addr1 = a1;
      @(posedge clk); @(negedge clk);
      chk("R6 wait state", {31'd0, ack_n}, 32'd1);
      if (chg) pending = newp;
      @(posedge clk); @(negedge clk);
      got = !ack_n; oe = data_oe; v = data_out;
      @(posedge clk); @(negedge clk);
      chk("R10 single ack", {31'd0, ack_n}, 32'd1);
      int_sel_n = 1'b1; addr1 = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic got, oe;
      logic [7:0] v;
      logic [3:0] user;
      void'($urandom(32'd1234));
      rst_n = 1'b0; pending = '0; vec_wr = 1'b0; vec_wdata = '0;
      int_sel_n = 1'b1; addr1 = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ack_n", {31'd0, ack_n}, 32'd1);
      chk("R1 data_oe", {31'd0, data_oe}, 32'd0);
      chk("R1 data_out", {24'd0, data_out}, 32'd0);
      chk("R9 idle request", {31'd0, irq_req_n}, 32'd1);

      // R1 reset field zero, R8 empty cycle still acked
      ack_cycle(1'b0, 1'b0, '0, got, oe, v);
      chk("R8 acked", {31'd0, got}, 32'd1);
      chk("R1 R8 vector", {24'd0, v}, 32'h00);

      // R4 low nibble ignored
      wr_vec(8'hA7);
      pending = 12'h001;
      ack_cycle(1'b0, 1'b0, '0, got, oe, v);
      chk("R4 R3 vector", {24'd0, v}, 32'hA0);
      chk("R6 data_oe", {31'd0, oe}, 32'd1);

      // R5 line 1 ignored
      ack_cycle(1'b1, 1'b0, '0, got, oe, v);
      chk("R5 no ack", {31'd0, got}, 32'd0);
      chk("R5 no drive", {31'd0, oe}, 32'd0);
      chk("R11 quiet", {24'd0, v}, 32'd0);

      // R7 pending changes during wait
      pending = 12'h010;
      ack_cycle(1'b0, 1'b1, 12'h800, got, oe, v);
      chk("R7 captured", {24'd0, v}, 32'hA4);

      // R9 served in order as winners are cleared
      pending = 12'hC21;
      @(negedge clk);
      chk("R9 request", {31'd0, irq_req_n}, 32'd0);
      ack_cycle(1'b0, 1'b0, '0, got, oe, v);
      chk("R2 R9 first", {24'd0, v}, 32'hAB);
      pending = 12'h421;
      ack_cycle(1'b0, 1'b0, '0, got, oe, v);
      chk("R9 second", {24'd0, v}, 32'hAA);
      pending = 12'h021;
      ack_cycle(1'b0, 1'b0, '0, got, oe, v);
      chk("R9 third", {24'd0, v}, 32'hA5);
      pending = 12'h000;
      @(negedge clk);
      chk("R9 released", {31'd0, irq_req_n}, 32'd1);

      // random mix
      for (int it = 0; it < 200; it++) begin
         logic [NUM_CH-1:0] p;
         logic a1;
         user = 4'($urandom);
         wr_vec({user, 4'($urandom)});
         p = NUM_CH'($urandom) & NUM_CH'($urandom);
         a1 = ($urandom % 5) == 0;
         pending = p;
         @(negedge clk);
         chk("R9 random request", {31'd0, irq_req_n}, {31'd0, (p == '0)});
         ack_cycle(a1, 1'b1, NUM_CH'($urandom), got, oe, v);
         if (a1) begin
            chk("R5 random ignore", {31'd0, got}, 32'd0);
         end else begin
            chk("R2 R3 random vector", {24'd0, v}, {24'd0, user, top_chan(p)});
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule